// File: doc/BRIEF.md
# PHY Management Register Stub

This block is the host-side management engine of a 10/100 Ethernet controller, merged with a minimal PHY register file. The host programs three write-only management registers through a simple write strobe: a target (PHY address plus register index), a 16-bit outgoing data word, and a command word. It reads results from the returned-data output and the link-fail flag. Accesses reach only the one PHY address the block answers to. They land in a 16-entry array of 16-bit registers, which holds control, status, two identifier words, an advertisement word and a link-partner ability word, along with general-purpose entries.

A link-status input is folded into the status and partner-ability registers whenever it changes. When link scanning is enabled it also drives the link-fail flag. The serial management waveform and auto-negotiation timing are not modelled. Every access completes in one clock cycle.

Top module: `phy_mgmt_stub`

## Requirements
- R1: After reset, rd_data is 0, link_fail is 0, and PHY registers read as: index 0 = 0x1000, 1 = 0x7848, 2 = 0x2000, 3 = 0x5c90, 4 = 0x01e1, 5 = 0x0000 (link down at reset), all other entries 0.
- R2: At the first clock edge where link_up differs from its previous sampled value, status bit 2 takes the new link value, and partner ability is ORed with 0x01e1 (link up) or ANDed with 0x01ff (link down). No change occurs on other cycles.
- R3: A PHY write to index 0 with bit 15 set restores every PHY register to its R1 value, then applies the current link_up as in R2. A write to index 0 with bit 15 clear stores the value.
- R4: PHY writes to index 1, 2 and 3 are ignored.
- R5: wr_sel selects the host register: 0 = target (PHY address in bits 4:0, register index in bits 12:8), 1 = outgoing data (16 bits), 2 = command. Value 3 is ignored.
- R6: Command bit 2 writes the stored outgoing data into the targeted register when the PHY address is 1. Any other address has no effect.
- R7: Command bit 1 loads rd_data one cycle later. With PHY address 1 it loads the targeted register, including a write from the same command. With any other address it loads 0xffff. In both cases link_fail is set to the inverse of link_up.
- R8: Writing the outgoing-data register while the PHY address is 1 immediately writes that value into the targeted register.
- R9: Command bit 0 is stored as scan enable. While it is set, an R2 link change sets link_fail to the inverse of the new link value. While it is clear, link changes leave link_fail unchanged.
- R10: Register indices 16 to 31 ignore writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Current link state, 1 = up |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Host register select (R5) |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Returned PHY data |
| link_fail | output | 1 | Link-fail status |

## Verification
Every result is due one clock edge after its stimulus. A read command's rd_data and link_fail appear at the edge that samples the command. A link change lands in the PHY registers and, with scanning on, in link_fail at the first edge that samples the new link_up. The driver stamps each expected item with the cycle index after the next rising edge. The monitor compares it at the falling edge of that cycle, so every comparison is made half a cycle after the edge that should produce the value.

// File: rtl/phy_mgmt_stub.sv
module phy_mgmt_stub #(
  parameter int PHY_ADDR = 1,
  parameter int NREG     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        link_fail
);
  localparam int RIW = $clog2(NREG);
  localparam logic [1:0] SEL_TGT = 2'd0, SEL_TXD = 2'd1, SEL_CMD = 2'd2;

  logic [15:0] regs    [NREG];
  logic [15:0] regs_nx [NREG];
  logic [4:0]  phy_q, rgad_q;
  logic [15:0] txd_q;
  logic        scan_q, link_q;

  function automatic logic [15:0] stat_apply(input logic [15:0] s, input logic up);
    return up ? (s | 16'h0004) : (s & ~16'h0004);
  endfunction
  function automatic logic [15:0] lp_apply(input logic [15:0] s, input logic up);
    return up ? (s | 16'h01e1) : (s & 16'h01ff);
  endfunction

  wire phy_hit  = (phy_q == 5'(PHY_ADDR));
  wire in_range = (int'(rgad_q) < NREG);
  wire lchg     = (link_up != link_q);
  wire cmd_wr   = wr_en && (wr_sel == SEL_CMD);
  wire rd_cmd   = cmd_wr && wr_data[1];

  logic        w_en;
  logic [15:0] w_val;

  always_comb begin
    regs_nx = regs;
    if (lchg) begin
      regs_nx[1] = stat_apply(regs[1], link_up);
      regs_nx[5] = lp_apply(regs[5], link_up);
    end
    w_en  = 1'b0;
    w_val = wr_data;
    if (wr_en && wr_sel == SEL_TXD && phy_hit) w_en = 1'b1;
    if (cmd_wr && wr_data[2] && phy_hit) begin
      w_en  = 1'b1;
      w_val = txd_q;
    end
    if (w_en && in_range) begin
      case (rgad_q)
        5'd0: begin
          if (w_val[15]) begin
            for (int i = 0; i < NREG; i++) regs_nx[i] = '0;
            regs_nx[0] = 16'h1000;
            regs_nx[1] = stat_apply(16'h7848, link_up);
            regs_nx[2] = 16'h2000;
            regs_nx[3] = 16'h5c90;
            regs_nx[4] = 16'h01e1;
            regs_nx[5] = lp_apply(16'h0000, link_up);
          end else begin
            regs_nx[0] = w_val;
          end
        end
        5'd1, 5'd2, 5'd3: ;
        default: regs_nx[rgad_q[RIW-1:0]] = w_val;
      endcase
    end
  end

  wire [15:0] rd_nx = !phy_hit ? 16'hffff
                    : (in_range ? regs_nx[rgad_q[RIW-1:0]] : 16'h0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      regs[0]   <= 16'h1000;
      regs[1]   <= 16'h7848;
      regs[2]   <= 16'h2000;
      regs[3]   <= 16'h5c90;
      regs[4]   <= 16'h01e1;
      phy_q     <= '0;
      rgad_q    <= '0;
      txd_q     <= '0;
      scan_q    <= 1'b0;
      link_q    <= 1'b0;
      rd_data   <= '0;
      link_fail <= 1'b0;
    end else begin
      regs   <= regs_nx;
      link_q <= link_up;
      if (wr_en && wr_sel == SEL_TGT) begin
        phy_q  <= wr_data[4:0];
        rgad_q <= wr_data[12:8];
      end
      if (wr_en && wr_sel == SEL_TXD) txd_q <= wr_data;
      if (cmd_wr) scan_q <= wr_data[0];
      if (rd_cmd) begin
        rd_data   <= rd_nx;
        link_fail <= !link_up;
      end else if (scan_q && lchg) begin
        link_fail <= !link_up;
      end
    end
  end

  AST_OTHER_PHY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && !phy_hit) |=> (rd_data == 16'hffff)); // R7
  AST_READ_LINKFAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> (link_fail == !$past(link_up))); // R7
  AST_STATUS_TRACKS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up != link_q) |=> (regs[1][2] == $past(link_up))); // R2
  AST_ID_CONSTANT: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[2] == 16'h2000) && (regs[3] == 16'h5c90)); // R4
  AST_NOSCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_q && !rd_cmd) |=> $stable(link_fail)); // R9
  AST_CTRL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_hit && rgad_q == 5'd0 && wr_en &&
     ((wr_sel == SEL_TXD && wr_data[15]) || (wr_sel == SEL_CMD && wr_data[2] && txd_q[15])))
    |=> (regs[0] == 16'h1000)); // R3
endmodule

// File: tb/test_phy_mgmt_stub.sv
module test_phy_mgmt_stub;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, link_up = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        link_fail;

  phy_mgmt_stub i_phy_mgmt_stub (.clk, .rst_n, .link_up, .wr_en, .wr_sel,
                                 .wr_data, .rd_data, .link_fail);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit          q_lf [$];
  logic [15:0] q_val[$];
  int          q_due[$];
  string       q_tag[$];

  task automatic expect_next(bit is_lf, logic [15:0] v, string tag);
    q_lf.push_back(is_lf); q_val.push_back(v); q_due.push_back(cyc + 1); q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      automatic bit lf = q_lf.pop_front();
      automatic logic [15:0] v = q_val.pop_front();
      automatic string t = q_tag.pop_front();
      void'(q_due.pop_front());
      checks++;
      if (lf) begin
        if (link_fail !== v[0]) begin
          fails++; $display("FAIL %s link_fail actual=%0b expected=%0b", t, link_fail, v[0]);
        end
      end else if (rd_data !== v) begin
        fails++; $display("FAIL %s rd_data actual=%h expected=%h", t, rd_data, v);
      end
    end
  end

  task automatic wr(logic [1:0] s, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
  endtask
  task automatic idle();
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic tgt(int phy, int r);
    wr(2'd0, {3'b0, 5'(r), 3'b0, 5'(phy)});
  endtask
  task automatic rd(int phy, int r, logic [15:0] ev, string tag);
    tgt(phy, r);
    wr(2'd2, 16'h0002);
    expect_next(0, ev, tag);
    expect_next(1, {15'b0, !link_up}, tag);
    idle();
  endtask
  task automatic setlink(bit v, bit exp_lf, string tag);
    @(negedge clk); wr_en = 1'b0; link_up = v;
    expect_next(1, {15'b0, exp_lf}, tag);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++; if (rd_data !== 16'h0 || link_fail !== 1'b0) begin
      fails++; $display("FAIL R1 reset outputs actual=%h/%b expected=0000/0", rd_data, link_fail);
    end
    // R1 reset contents
    rd(1, 0, 16'h1000, "R1"); rd(1, 1, 16'h7848, "R1"); rd(1, 2, 16'h2000, "R1");
    rd(1, 3, 16'h5c90, "R1"); rd(1, 4, 16'h01e1, "R1"); rd(1, 5, 16'h0000, "R1");
    rd(1, 9, 16'h0000, "R1");
    // R9 scan off: link change leaves link_fail at 1
    setlink(1, 1, "R9");
    // R2 link up
    rd(1, 1, 16'h784c, "R2"); rd(1, 5, 16'h01e1, "R2");
    // R8 immediate write through outgoing data
    tgt(1, 5); wr(2'd1, 16'hfe00); idle();
    rd(1, 5, 16'hfe00, "R8");
    setlink(0, 0, "R9");
    rd(1, 5, 16'h0000, "R2"); rd(1, 1, 16'h7848, "R2");
    setlink(1, 1, "R9");
    rd(1, 5, 16'h01e1, "R2");
    // R4 read-only registers
    tgt(2, 1); wr(2'd1, 16'h0000); tgt(1, 1); wr(2'd2, 16'h0004); idle();
    rd(1, 1, 16'h784c, "R4");
    tgt(1, 2); wr(2'd2, 16'h0004); idle();
    rd(1, 2, 16'h2000, "R4");
    tgt(1, 3); wr(2'd1, 16'h1111); idle();
    rd(1, 3, 16'h5c90, "R4");
    // R6 command write, R5 field layout, select 3 ignored
    tgt(2, 6); wr(2'd1, 16'habcd); tgt(1, 6); wr(2'd2, 16'h0004); wr(2'd3, 16'h0000); idle();
    rd(1, 6, 16'habcd, "R6");
    // R7 write and read in one command
    tgt(2, 7); wr(2'd1, 16'h1234); tgt(1, 7); wr(2'd2, 16'h0006);
    expect_next(0, 16'h1234, "R7"); idle();
    // R6 other PHY address ignored, R7 other PHY reads ones
    tgt(3, 6); wr(2'd1, 16'h5555); wr(2'd2, 16'h0004); idle();
    rd(3, 6, 16'hffff, "R7");
    rd(1, 6, 16'habcd, "R6");
    // R10 out-of-range index
    tgt(1, 20); wr(2'd1, 16'h7777); idle();
    rd(1, 20, 16'h0000, "R10"); rd(1, 4, 16'h01e1, "R10");
    // R3 control store and soft reset
    tgt(1, 0); wr(2'd1, 16'h0100); idle();
    rd(1, 0, 16'h0100, "R3");
    wr(2'd1, 16'h8000); idle();
    rd(1, 0, 16'h1000, "R3"); rd(1, 6, 16'h0000, "R3"); rd(1, 7, 16'h0000, "R3");
    rd(1, 5, 16'h01e1, "R3"); rd(1, 1, 16'h784c, "R3");
    // R9 scan on
    wr(2'd2, 16'h0001); idle();
    setlink(0, 1, "R9");
    setlink(1, 0, "R9");
    wr(2'd2, 16'h0000); idle();
    setlink(0, 0, "R9");
    idle();
    rd(1, 1, 16'h7848, "R9");
    repeat (3) idle();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule